// File: doc/BRIEF.md
# Paired-Page Address Translation Lookup

This block is the lookup half of a fully associative address translation cache for a 32-bit core. Every slot covers two neighbouring virtual pages, an even one and an odd one. A slot holds a page-pair tag, a size mask, an 8-bit address-space identifier, a global flag, and two physical frame bases. Each frame base has its own valid flag and writable (dirty) flag. The smallest page is 4 KB. A non-zero size mask makes both pages of the pair larger by the same amount.

A request carries a virtual address, the current address-space identifier and a store flag. One cycle later the block returns one of four results: hit, miss, invalid or modified. On a hit it also returns the translated physical address, a read grant and a write grant. The response also reports which slot produced the result. Slots are loaded one at a time through a write port addressed by slot number. An occupancy input limits the search to the slots below that number. Choosing which slot to replace and refilling slots after a miss are tasks for the surrounding core.

Top module: `tlb_lookup`

## Requirements
- R1: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. The response fields (`rsp_code`, `rsp_pa`, `rsp_rd`, `rsp_wr`, `rsp_idx`) describe the request from that earlier cycle.
- R2: A slot matches when two conditions both hold. First, its global flag is set or its identifier equals `req_asid`. Second, the request address equals the slot tag once all bits under the effective mask are cleared in both. A non-global slot with a different identifier never matches.
- R3: The effective mask is `wr_mask` placed at bits 28..13, ORed with 0x1FFF. For example, `wr_mask`=0 gives a 4 KB page per half and `wr_mask`=3 gives a 16 KB page per half.
- R4: The half is chosen by the highest bit of the effective mask, which is bit 12 for `wr_mask`=0 and bit 14 for `wr_mask`=3. When that address bit is 0 the even frame is used; when it is 1 the odd frame is used.
- R5: If the chosen half is not valid, the result is invalid. The address and both grants are then zero.
- R6: A store to a valid half whose writable flag is clear gives the result modified. A load from a valid half is a hit whatever the writable flag is.
- R7: On a hit, `rsp_pa` is the chosen frame base with its bits under the half mask cleared, ORed with the request address bits under the half mask. The half mask is the effective mask shifted right by one. `rsp_rd` is 1 and `rsp_wr` equals the chosen writable flag.
- R8: Result codes on `rsp_code` are: 0 for hit, 1 for miss, 2 for invalid and 3 for modified. When no slot matches, the result is miss, with zero address, both grants 0 and `rsp_idx` 0.
- R9: Only slots with an index below `use_cnt` take part in the search. When `use_cnt` is 0, every request misses.
- R10: When several slots match, the lowest-numbered one decides the result, and `rsp_idx` reports its number.
- R11: After reset every slot holds all-zero fields, with both halves invalid.
- R12: A slot write takes effect in one cycle. A lookup presented in the same cycle sees the slot's previous contents. A lookup in the following cycle sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual address to translate |
| req_asid | input | 8 | Current address-space identifier |
| req_write | input | 1 | 1 for a store, 0 for a load |
| use_cnt | input | 4 | Number of slots searched, counted from slot 0 |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 3 | Slot number to write |
| wr_vpn | input | 32 | Page-pair tag (virtual address form) |
| wr_mask | input | 16 | Size mask, applied at address bits 28..13 |
| wr_asid | input | 8 | Slot address-space identifier |
| wr_global | input | 1 | Match under any identifier |
| wr_pfn0 | input | 32 | Even-page frame base |
| wr_v0 | input | 1 | Even page valid |
| wr_d0 | input | 1 | Even page writable |
| wr_pfn1 | input | 32 | Odd-page frame base |
| wr_v1 | input | 1 | Odd page valid |
| wr_d1 | input | 1 | Odd page writable |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 2 | Result: 0 hit, 1 miss, 2 invalid, 3 modified |
| rsp_pa | output | 32 | Physical address (zero unless hit) |
| rsp_rd | output | 1 | Read granted |
| rsp_wr | output | 1 | Write granted |
| rsp_idx | output | 3 | Number of the deciding slot |

## Verification
Loads and stores go to both halves of a 4 KB-page slot, which separates even from odd selection. A store to a clean half separates modified from hit. A 16 KB-page slot is tried with a foreign identifier while marked global, and with offsets that straddle the half bit and the pair boundary. This shows that the mask is applied both when matching and when selecting the half. Two slots are given the same tag, and requests are sent with the occupancy limit on either side of the higher one. These requests tell lowest-index priority apart from the occupancy cutoff. A slot write issued together with a lookup shows whether the lookup sees the old or the new contents.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W      = 32;
  localparam int ASID_W    = 8;
  localparam int MASK_W    = 16;
  localparam int FIX_BITS  = 13;
  localparam int PAD_W     = VA_W - MASK_W - FIX_BITS;

  typedef enum logic [1:0] {
    RES_HIT      = 2'd0,
    RES_MISS     = 2'd1,
    RES_INVALID  = 2'd2,
    RES_MODIFIED = 2'd3
  } res_e;

  typedef struct packed {
    logic [VA_W-1:0]   vpn;
    logic [MASK_W-1:0] mask;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [VA_W-1:0]   pfn0;
    logic              v0;
    logic              d0;
    logic [VA_W-1:0]   pfn1;
    logic              v1;
    logic              d1;
  } entry_t;

  function automatic logic [VA_W-1:0] eff_mask(input logic [MASK_W-1:0] m);
    logic [VA_W-1:0] r;
    r = {{PAD_W{1'b0}}, m, {FIX_BITS{1'b0}}};
    r = r | {{(VA_W-FIX_BITS){1'b0}}, {FIX_BITS{1'b1}}};
    return r;
  endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  entry_t                    wr_entry,
  output entry_t [ENTRIES-1:0]      ents
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    entry_t slot_q;
    entry_t slot_d;
    logic   slot_we;

    always_comb begin
      slot_we = wr_en && (wr_idx == IDX_W'(i));
      slot_d  = slot_we ? wr_entry : slot_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (slot_we) begin
        slot_q <= slot_d;
      end
    end

    assign ents[i] = slot_q;
  end
endmodule

// File: rtl/tlb_match_array.sv
module tlb_match_array
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int CNT_W   = $clog2(ENTRIES + 1)
) (
  input  entry_t [ENTRIES-1:0] ents,
  input  logic [VA_W-1:0]      va,
  input  logic [ASID_W-1:0]    asid,
  input  logic [CNT_W-1:0]     use_cnt,
  output logic [ENTRIES-1:0]   hit
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [VA_W-1:0] em;
    logic            in_use;
    logic            id_ok;
    logic            tag_ok;

    always_comb begin
      em     = eff_mask(ents[i].mask);
      in_use = CNT_W'(i) < use_cnt;
      id_ok  = ents[i].glob || (ents[i].asid == asid);
      tag_ok = (va & ~em) == (ents[i].vpn & ~em);
      hit[i] = in_use && id_ok && tag_ok;
    end
  end
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] hit,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve
  import tlb_pkg::*;
(
  input  entry_t          ent,
  input  logic            any,
  input  logic [VA_W-1:0] va,
  input  logic            write,
  output res_e            code,
  output logic [VA_W-1:0] pa,
  output logic            rd,
  output logic            wr
);
  logic [VA_W-1:0] em;
  logic [VA_W-1:0] half;
  logic            odd;
  logic            sel_v;
  logic            sel_d;
  logic [VA_W-1:0] sel_pfn;

  always_comb begin
    em      = eff_mask(ent.mask);
    half    = em >> 1;
    odd     = |(va & em & ~half);
    sel_v   = odd ? ent.v1   : ent.v0;
    sel_d   = odd ? ent.d1   : ent.d0;
    sel_pfn = odd ? ent.pfn1 : ent.pfn0;

    code = RES_MISS;
    pa   = '0;
    rd   = 1'b0;
    wr   = 1'b0;
    if (any) begin
      if (!sel_v) begin
        code = RES_INVALID;
      end else if (write && !sel_d) begin
        code = RES_MODIFIED;
      end else begin
        code = RES_HIT;
        pa   = (sel_pfn & ~half) | (va & half);
        rd   = 1'b1;
        wr   = sel_d;
      end
    end
  end
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int CNT_W   = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_va,
  input  logic [7:0]        req_asid,
  input  logic              req_write,
  input  logic [CNT_W-1:0]  use_cnt,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [31:0]       wr_vpn,
  input  logic [15:0]       wr_mask,
  input  logic [7:0]        wr_asid,
  input  logic              wr_global,
  input  logic [31:0]       wr_pfn0,
  input  logic              wr_v0,
  input  logic              wr_d0,
  input  logic [31:0]       wr_pfn1,
  input  logic              wr_v1,
  input  logic              wr_d1,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [31:0]       rsp_pa,
  output logic              rsp_rd,
  output logic              rsp_wr,
  output logic [IDX_W-1:0]  rsp_idx
);
  entry_t               wr_entry;
  entry_t [ENTRIES-1:0] ents;
  logic [ENTRIES-1:0]   hit;
  logic                 any;
  logic [IDX_W-1:0]     pick;
  entry_t               chosen;
  res_e                 code_c;
  logic [VA_W-1:0]      pa_c;
  logic                 rd_c;
  logic                 wr_c;

  always_comb begin
    wr_entry.vpn  = wr_vpn;
    wr_entry.mask = wr_mask;
    wr_entry.asid = wr_asid;
    wr_entry.glob = wr_global;
    wr_entry.pfn0 = wr_pfn0;
    wr_entry.v0   = wr_v0;
    wr_entry.d0   = wr_d0;
    wr_entry.pfn1 = wr_pfn1;
    wr_entry.v1   = wr_v1;
    wr_entry.d1   = wr_d1;
  end

  tlb_entry_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_entry (wr_entry),
    .ents     (ents)
  );

  tlb_match_array #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_match (
    .ents    (ents),
    .va      (req_va),
    .asid    (req_asid),
    .use_cnt (use_cnt),
    .hit     (hit)
  );

  tlb_first_hit #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .hit (hit),
    .any (any),
    .idx (pick)
  );

  assign chosen = ents[pick];

  tlb_resolve u_resolve (
    .ent   (chosen),
    .any   (any),
    .va    (req_va),
    .write (req_write),
    .code  (code_c),
    .pa    (pa_c),
    .rd    (rd_c),
    .wr    (wr_c)
  );

  // response registers: next-state then storage
  logic              vld_d, vld_q;
  logic [1:0]        code_d, code_q;
  logic [VA_W-1:0]   pa_d, pa_q;
  logic              rd_d, rd_q, wrp_d, wrp_q;
  logic [IDX_W-1:0]  idx_d, idx_q;

  always_comb begin
    vld_d  = req_valid;
    code_d = code_c;
    pa_d   = pa_c;
    rd_d   = rd_c;
    wrp_d  = wr_c;
    idx_d  = pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= RES_MISS;
      pa_q   <= '0;
      rd_q   <= 1'b0;
      wrp_q  <= 1'b0;
      idx_q  <= '0;
    end else if (req_valid) begin
      code_q <= code_d;
      pa_q   <= pa_d;
      rd_q   <= rd_d;
      wrp_q  <= wrp_d;
      idx_q  <= idx_d;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_code  = code_q;
  assign rsp_pa    = pa_q;
  assign rsp_rd    = rd_q;
  assign rsp_wr    = wrp_q;
  assign rsp_idx   = idx_q;

  p_rsp_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_fail_no_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != RES_HIT) |-> (!rsp_rd && !rsp_wr && rsp_pa == '0));
  p_modified_on_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ((rsp_code == RES_MODIFIED) -> $past(req_write)));
  p_wr_needs_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_wr) |-> rsp_rd);
  p_empty_misses_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && use_cnt == '0) |=> (rsp_code == RES_MISS));
endmodule

// File: tb/tlb_lookup_test.sv
module tlb_lookup_test;
  import tlb_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_va;
  logic [7:0]  req_asid;
  logic [3:0]  use_cnt;
  logic        wr_en, wr_global, wr_v0, wr_d0, wr_v1, wr_d1;
  logic [2:0]  wr_idx;
  logic [31:0] wr_vpn, wr_pfn0, wr_pfn1;
  logic [15:0] wr_mask;
  logic [7:0]  wr_asid;
  logic        rsp_valid, rsp_rd, rsp_wr;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_pa;
  logic [2:0]  rsp_idx;

  always #4 clk = ~clk;

  tlb_lookup uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_asid(req_asid), .req_write(req_write), .use_cnt(use_cnt),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_mask(wr_mask),
    .wr_asid(wr_asid), .wr_global(wr_global), .wr_pfn0(wr_pfn0),
    .wr_v0(wr_v0), .wr_d0(wr_d0), .wr_pfn1(wr_pfn1), .wr_v1(wr_v1),
    .wr_d1(wr_d1), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .rsp_pa(rsp_pa), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_idx(rsp_idx)
  );

  typedef struct {
    logic [1:0]  code;
    logic [31:0] pa;
    logic        rd;
    logic        wr;
    logic [2:0]  idx;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // monitor: compare each response against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 response without request", 32'(rsp_valid), 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rsp_code == e.code, {e.tag, " code"}, 32'(rsp_code), 32'(e.code));
        check(rsp_pa == e.pa, {e.tag, " pa"}, rsp_pa, e.pa);
        check({rsp_rd, rsp_wr} == {e.rd, e.wr}, {e.tag, " perms"},
              32'({rsp_rd, rsp_wr}), 32'({e.rd, e.wr}));
        check(rsp_idx == e.idx, {e.tag, " idx"}, 32'(rsp_idx), 32'(e.idx));
      end
    end
  end

  task automatic set_slot(input logic [2:0] idx, input logic [31:0] vpn,
                          input logic [15:0] mask, input logic [7:0] asid,
                          input logic g, input logic [31:0] p0, input logic v0,
                          input logic d0, input logic [31:0] p1, input logic v1,
                          input logic d1);
    wr_idx = idx; wr_vpn = vpn; wr_mask = mask; wr_asid = asid; wr_global = g;
    wr_pfn0 = p0; wr_v0 = v0; wr_d0 = d0; wr_pfn1 = p1; wr_v1 = v1; wr_d1 = d1;
  endtask

  task automatic load(input logic [2:0] idx, input logic [31:0] vpn,
                      input logic [15:0] mask, input logic [7:0] asid,
                      input logic g, input logic [31:0] p0, input logic v0,
                      input logic d0, input logic [31:0] p1, input logic v1,
                      input logic d1);
    @(negedge clk);
    set_slot(idx, vpn, mask, asid, g, p0, v0, d0, p1, v1, d1);
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push(input logic [1:0] code, input logic [31:0] pa,
                      input logic rd, input logic wr, input logic [2:0] idx,
                      input string tag);
    exp_t e;
    e.code = code; e.pa = pa; e.rd = rd; e.wr = wr; e.idx = idx; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic lookup(input logic [31:0] va, input logic [7:0] asid,
                        input logic wr, input logic [1:0] code,
                        input logic [31:0] pa, input logic rd, input logic wp,
                        input logic [2:0] idx, input string tag);
    @(negedge clk);
    req_va = va; req_asid = asid; req_write = wr; req_valid = 1'b1;
    push(code, pa, rd, wp, idx, tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_va = '0;
    req_asid = '0; use_cnt = 4'd8; wr_en = 1'b0;
    set_slot(3'd0, 32'h0, 16'h0, 8'h0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1 idle after reset", 32'(rsp_valid), 32'h0);

    // R11: cleared slot 0 matches address 0 / id 0 but both halves invalid
    lookup(32'h0000_0000, 8'h00, 1'b0, RES_INVALID, 32'h0, 1'b0, 1'b0, 3'd0, "R11 reset slot");

    load(3'd0, 32'h0040_0000, 16'h0, 8'h05, 1'b0,
         32'h1000_0000, 1'b1, 1'b1, 32'h2000_0000, 1'b1, 1'b0);
    lookup(32'h0040_0123, 8'h05, 1'b0, RES_HIT, 32'h1000_0123, 1'b1, 1'b1, 3'd0, "R2 R7 even load");
    lookup(32'h0040_1abc, 8'h05, 1'b0, RES_HIT, 32'h2000_0abc, 1'b1, 1'b0, 3'd0, "R4 R6 odd clean load");
    lookup(32'h0040_1abc, 8'h05, 1'b1, RES_MODIFIED, 32'h0, 1'b0, 1'b0, 3'd0, "R6 store clean");
    lookup(32'h0040_0010, 8'h05, 1'b1, RES_HIT, 32'h1000_0010, 1'b1, 1'b1, 3'd0, "R7 store dirty");
    lookup(32'h0040_0123, 8'h06, 1'b0, RES_MISS, 32'h0, 1'b0, 1'b0, 3'd0, "R2 R8 foreign id");

    // 16 KB halves, global, frame base with stray low bits
    load(3'd1, 32'h0080_0000, 16'h0003, 8'h09, 1'b1,
         32'h0300_2fff, 1'b1, 1'b1, 32'h0500_4000, 1'b0, 1'b1);
    lookup(32'h0080_3456, 8'h02, 1'b0, RES_HIT, 32'h0300_3456, 1'b1, 1'b1, 3'd1, "R3 R2 R7 global big page");
    lookup(32'h0080_7456, 8'h02, 1'b0, RES_INVALID, 32'h0, 1'b0, 1'b0, 3'd1, "R4 R5 odd invalid");
    lookup(32'h0080_8000, 8'h02, 1'b0, RES_MISS, 32'h0, 1'b0, 1'b0, 3'd0, "R3 beyond pair");

    // R10: duplicate tag in slot 3
    load(3'd3, 32'h0040_0000, 16'h0, 8'h05, 1'b0,
         32'h0700_0000, 1'b1, 1'b1, 32'h0, 1'b0, 1'b0);
    lookup(32'h0040_0200, 8'h05, 1'b0, RES_HIT, 32'h1000_0200, 1'b1, 1'b1, 3'd0, "R10 lowest wins");
    load(3'd0, 32'h0040_0000, 16'h0, 8'h07, 1'b0,
         32'h1000_0000, 1'b1, 1'b1, 32'h2000_0000, 1'b1, 1'b0);
    lookup(32'h0040_0200, 8'h05, 1'b0, RES_HIT, 32'h0700_0200, 1'b1, 1'b1, 3'd3, "R10 next slot");

    // R9: occupancy limit
    @(negedge clk); use_cnt = 4'd3;
    lookup(32'h0040_0200, 8'h05, 1'b0, RES_MISS, 32'h0, 1'b0, 1'b0, 3'd0, "R9 slot above limit");
    @(negedge clk); use_cnt = 4'd0;
    lookup(32'h0080_3456, 8'h02, 1'b0, RES_MISS, 32'h0, 1'b0, 1'b0, 3'd0, "R9 empty");
    @(negedge clk); use_cnt = 4'd4;
    lookup(32'h0040_0200, 8'h05, 1'b0, RES_HIT, 32'h0700_0200, 1'b1, 1'b1, 3'd3, "R9 slot at limit");

    // R12: write and lookup in the same cycle
    @(negedge clk);
    set_slot(3'd3, 32'h0040_0000, 16'h0, 8'h05, 1'b0,
             32'h0900_0000, 1'b1, 1'b1, 32'h0, 1'b0, 1'b0);
    wr_en = 1'b1;
    req_va = 32'h0040_0200; req_asid = 8'h05; req_write = 1'b0; req_valid = 1'b1;
    push(RES_HIT, 32'h0700_0200, 1'b1, 1'b1, 3'd3, "R12 old contents");
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    lookup(32'h0040_0200, 8'h05, 1'b0, RES_HIT, 32'h0900_0200, 1'b1, 1'b1, 3'd3, "R12 new contents");

    repeat (2) @(negedge clk);
    check(rsp_valid == 1'b0, "R1 idle after traffic", 32'(rsp_valid), 32'h0);
    check(exp_q.size() == 0, "R1 all responses seen", 32'(exp_q.size()), 32'h0);
    finish_run();
  end
endmodule